// File: doc/BRIEF.md
# Round-Registered AES-128 Cipher Pipeline

This block carries out AES-128 encryption or decryption on 128-bit blocks. It accepts a new block on every clock and returns one finished block per clock. Each of the eleven round boundaries has its own register. The first stage only XORs in round key 0. Nine middle stages each perform substitution, row rotation, column mixing and key addition. The last stage skips the column mixing. The direction bit is captured with each block and moves through the pipeline beside it.

Decryption uses the equivalent inverse cipher, so both directions go through the same stage sequence. Only the byte substitution, the row rotation direction and the mixing coefficients change between them. Key expansion is done outside the block. All eleven round keys arrive expanded on one wide port, and they must stay stable while blocks are in flight. For decryption, the caller reverses the key order and applies inverse column mixing to the nine middle keys. The substitution box is computed in logic as a multiplicative inverse in GF(2^8) together with an affine map, so no table memory is used.

Top module: `aes128_round_pipe`

## Requirements
- R1: With in_decrypt=0, key 000102030405060708090a0b0c0d0e0f and input block 00112233445566778899aabbccddeeff, the result is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: With in_decrypt=1, ciphertext is turned back into plaintext under this key layout: slot 0 holds encryption round key 10; slot i, for i from 1 to 9, holds inverse-column-mixed encryption round key 10-i; slot 10 holds round key 0.
- R3: Byte 0 of a block is bits [127:120], and state column c consists of bytes 4c to 4c+3. Stage r takes its key from round_keys[128*r +: 128], for r from 0 to 10.
- R4: A block presented with in_valid high at a clock edge appears on out_block with out_valid high 11 clock edges later. Each accepted block produces exactly one valid output.
- R5: Blocks presented on consecutive cycles come out on consecutive cycles, in the same order, and each result is correct.
- R6: The direction of a block is fixed by in_decrypt at the edge where the block is accepted. Later changes to in_decrypt do not alter a block already in flight.
- R7: out_valid is low while rst_n is low, and it stays low for at least 11 cycles after reset is released.
- R8: While out_valid is low, out_block keeps the last result.
- R9: When in_valid is held low, out_valid never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the valid pipeline |
| in_valid | input | 1 | A block is presented this cycle |
| in_decrypt | input | 1 | 1 selects decryption, 0 selects encryption |
| in_block | input | 128 | Input block, byte 0 in the top bits |
| round_keys | input | 1408 | Eleven 128-bit round keys, slot r at bits 128*r+127 down to 128*r |
| out_valid | output | 1 | out_block holds a new result |
| out_block | output | 128 | Result block |

## Verification
A single standard known-answer block is run in each direction. It separates a correct round structure, byte order and key slot order from nearly any single fault in substitution, rotation, mixing or key selection. A burst of four consecutive blocks has a repeated plaintext at positions one and three, which must give identical ciphertexts, and distinct neighbours, which must not. The burst is then decrypted back to back to confirm one result per cycle and the ordering. A lone block followed by a toggle of the direction input shows that the mode stays bound to the block. Idle stretches show that valid never appears on its own and that the output holds its last value.

// File: rtl/aes128_round_pipe.sv
module aes128_round_pipe (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_decrypt,
  input  logic [127:0]    in_block,
  input  logic [1407:0]   round_keys,
  output logic            out_valid,
  output logic [127:0]    out_block
);
  localparam int NST = 11;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, p;
    r = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = xt(p);
    end
    return r;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] r, p;
    r = 8'h01;
    p = x;
    for (int k = 1; k < 8; k++) begin
      p = gm(p, p);
      r = gm(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] x, input int n);
    return 8'((x << n) | (x >> (8 - n)));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] b, input logic dec);
    logic [7:0] t;
    if (dec) begin
      t = rl(b, 1) ^ rl(b, 3) ^ rl(b, 6) ^ 8'h05;
      return ginv(t);
    end
    t = ginv(b);
    return t ^ rl(t, 1) ^ rl(t, 2) ^ rl(t, 3) ^ rl(t, 4) ^ 8'h63;
  endfunction

  function automatic logic [127:0] rnd(input logic [127:0] s, input logic [127:0] k,
                                       input logic dec, input logic last);
    logic [7:0] a [16];
    logic [7:0] b [16];
    logic [7:0] m [16];
    logic [7:0] cf [4];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) a[i] = sbox(s[127-8*i -: 8], dec);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        b[r+4*c] = dec ? a[r+4*((c-r+4)%4)] : a[r+4*((c+r)%4)];
    if (dec) begin
      cf[0] = 8'h0e; cf[1] = 8'h0b; cf[2] = 8'h0d; cf[3] = 8'h09;
    end else begin
      cf[0] = 8'h02; cf[1] = 8'h03; cf[2] = 8'h01; cf[3] = 8'h01;
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        m[r+4*c] = 8'h00;
        for (int j = 0; j < 4; j++) m[r+4*c] = m[r+4*c] ^ gm(b[4*c+(r+j)%4], cf[j]);
      end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = last ? b[i] : m[i];
    return o ^ k;
  endfunction

  logic [127:0]   st [NST];
  logic [NST-1:0] vl, dc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vl <= '0;
      dc <= '0;
    end else begin
      vl <= {vl[NST-2:0], in_valid};
      if (in_valid) dc[0] <= in_decrypt;
      for (int i = 1; i < NST; i++)
        if (vl[i-1]) dc[i] <= dc[i-1];
    end

  always_ff @(posedge clk)
    if (in_valid) st[0] <= in_block ^ round_keys[127:0];

  for (genvar g = 1; g < NST; g++) begin : g_round
    always_ff @(posedge clk)
      if (vl[g-1]) st[g] <= rnd(st[g-1], round_keys[128*g +: 128], dc[g-1], g == NST-1);
  end

  assign out_valid = vl[NST-1];
  assign out_block = st[NST-1];
endmodule

module aes128_round_pipe_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_decrypt,
  input logic         out_valid,
  input logic [127:0] out_block,
  input logic         last_dec
);
  logic [3:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != 4'hf) cyc <= cyc + 4'h1;

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 4'd11) |-> (out_valid == $past(in_valid, 11)));

  // R7
  quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc < 4'd11) |-> !out_valid);

  // R8
  hold_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc >= 4'd1) && !out_valid) |-> $stable(out_block));

  // R6
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc >= 4'd11) && out_valid) |-> (last_dec == $past(in_decrypt, 11)));
endmodule

bind aes128_round_pipe aes128_round_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_decrypt(in_decrypt),
  .out_valid(out_valid), .out_block(out_block), .last_dec(dc[10])
);

// File: tb/aes128_round_pipe_test.sv
`timescale 1ns/1ps
module aes128_round_pipe_test;
  localparam logic [127:0] KEY = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

  logic clk = 0, rst_n = 0, in_valid = 0, in_decrypt = 0;
  logic [127:0] in_block = '0;
  logic [1407:0] round_keys = '0;
  logic out_valid;
  logic [127:0] out_block;

  aes128_round_pipe uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_decrypt(in_decrypt),
    .in_block(in_block), .round_keys(round_keys), .out_valid(out_valid), .out_block(out_block));

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, nres = 0, nin = 0;
  logic [127:0] res [16];
  int rcyc [16];
  int icyc [16];
  logic [1407:0] ke, kd;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    if (rst_n && out_valid && nres < 16) begin
      res[nres] = out_block;
      rcyc[nres] = cyc;
      nres++;
    end

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] bsub(input logic [7:0] x);
    logic [7:0] v = 8'h00, o, c = 8'h63;
    for (int y = 1; y < 256; y++) if (bmul(x, 8'(y)) == 8'h01) v = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
    return o;
  endfunction

  function automatic logic [1407:0] expand(input logic [127:0] k);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    logic [1407:0] o;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {bsub(t[23:16]), bsub(t[15:8]), bsub(t[7:0]), bsub(t[31:24])} ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) o[128*r +: 128] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    return o;
  endfunction

  function automatic logic [127:0] imc(input logic [127:0] x);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = x[127-32*c -: 8]; a1 = x[119-32*c -: 8]; a2 = x[111-32*c -: 8]; a3 = x[103-32*c -: 8];
      o[127-32*c -: 8] = bmul(a0,8'h0e) ^ bmul(a1,8'h0b) ^ bmul(a2,8'h0d) ^ bmul(a3,8'h09);
      o[119-32*c -: 8] = bmul(a0,8'h09) ^ bmul(a1,8'h0e) ^ bmul(a2,8'h0b) ^ bmul(a3,8'h0d);
      o[111-32*c -: 8] = bmul(a0,8'h0d) ^ bmul(a1,8'h09) ^ bmul(a2,8'h0e) ^ bmul(a3,8'h0b);
      o[103-32*c -: 8] = bmul(a0,8'h0b) ^ bmul(a1,8'h0d) ^ bmul(a2,8'h09) ^ bmul(a3,8'h0e);
    end
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nres = 0;
    nin = 0;
  endtask

  task automatic send(input logic [127:0] b, input logic d);
    @(negedge clk);
    in_block = b; in_decrypt = d; in_valid = 1;
    icyc[nin] = cyc;
    nin++;
  endtask

  task automatic quiet(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R7 out_valid during reset", 128'(out_valid), 128'd0);
    rst_n = 1;
    quiet(15);
    chk(nres == 0, "R9 no output while idle", 128'(nres), 128'd0);
    chk(out_valid == 0, "R7 out_valid after reset", 128'(out_valid), 128'd0);
  endtask

  task automatic t_encrypt();
    round_keys = ke;
    clear_log();
    send(PT, 0);
    quiet(14);
    chk(nres == 1, "R4 one result per block", 128'(nres), 128'd1);
    chk(res[0] == CT, "R1 R3 encrypt vector", res[0], CT);
    chk(rcyc[0] - icyc[0] == 11, "R4 latency", 128'(rcyc[0] - icyc[0]), 128'd11);
    chk(out_block == CT, "R8 output held", out_block, CT);
  endtask

  task automatic t_decrypt();
    round_keys = kd;
    clear_log();
    send(CT, 1);
    quiet(14);
    chk(nres == 1, "R4 one result per block", 128'(nres), 128'd1);
    chk(res[0] == PT, "R2 decrypt vector", res[0], PT);
    chk(rcyc[0] - icyc[0] == 11, "R4 decrypt latency", 128'(rcyc[0] - icyc[0]), 128'd11);
  endtask

  task automatic t_mode_latch();
    round_keys = ke;
    clear_log();
    send(PT, 0);
    repeat (13) begin
      @(negedge clk);
      in_valid = 0;
      in_decrypt = 1;
    end
    chk(nres == 1, "R6 result count", 128'(nres), 128'd1);
    chk(res[0] == CT, "R6 mode held by block", res[0], CT);
  endtask

  task automatic t_burst();
    logic [127:0] p [4];
    logic [127:0] c [4];
    p[0] = PT; p[1] = PT ^ 128'h1; p[2] = PT; p[3] = ~PT;
    round_keys = ke;
    clear_log();
    for (int i = 0; i < 4; i++) send(p[i], 0);
    quiet(14);
    chk(nres == 4, "R5 burst count", 128'(nres), 128'd4);
    for (int i = 0; i < 4; i++) begin
      chk(rcyc[i] == rcyc[0] + i, "R5 consecutive outputs", 128'(rcyc[i] - rcyc[0]), 128'(i));
      chk(rcyc[i] - icyc[i] == 11, "R4 burst latency", 128'(rcyc[i] - icyc[i]), 128'd11);
      c[i] = res[i];
    end
    chk(c[0] == CT, "R5 burst block 0", c[0], CT);
    chk(c[2] == CT, "R5 burst block 2", c[2], CT);
    chk(c[1] != CT, "R5 burst block 1 differs", c[1], CT);
    chk(c[3] != c[1], "R5 burst block 3 differs", c[3], c[1]);
    round_keys = kd;
    clear_log();
    for (int i = 0; i < 4; i++) send(c[i], 1);
    quiet(14);
    chk(nres == 4, "R5 decrypt burst count", 128'(nres), 128'd4);
    for (int i = 0; i < 4; i++)
      chk(res[i] == p[i], "R2 R5 burst round trip", res[i], p[i]);
  endtask

  initial begin
    logic [1407:0] tmp;
    ke = expand(KEY);
    tmp[127:0] = ke[128*10 +: 128];
    for (int i = 1; i < 10; i++) tmp[128*i +: 128] = imc(ke[128*(10-i) +: 128]);
    tmp[128*10 +: 128] = ke[127:0];
    kd = tmp;
    t_reset();
    t_encrypt();
    t_decrypt();
    t_mode_latch();
    t_burst();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #500000;
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule